// File: doc/BRIEF.md
# Core and DMA External Bus Arbiter

This block picks, every clock cycle, which single requester may drive a shared external memory bus. Four requesters compete: three core access ports (program fetch, X data, Y data) and one DMA port. The core's standing against the DMA port is decided by comparing two 2-bit priority levels. The core level comes either from a static mode field or, when that field is zero, from a dynamic field in the status word. The DMA level is supplied by whichever DMA channel is currently active.

When the core level is higher, the core ports come first and the DMA port only gets the bus when no core port wants it. When the DMA level is higher, the reverse applies. When the levels are equal, all four ports share the bus through a round-robin rotation. A grant is registered and stays with its owner for as long as the owner keeps its request high. The next decision is made in the cycle in which that request drops.

Top module: `xbus_arbiter`

## Requirements
- R1: When `mode_prio` is 00, the core priority level equals `stat_prio` (00..11 giving levels 0..3).
- R2: When `mode_prio` is 01, 10 or 11, the core priority level is fixed at 0, 1 or 2 respectively, and `stat_prio` has no effect on any grant.
- R3: When the core level is above `dma_prio`, a new grant goes to a core port whenever any core port requests. `gnt_dma` is given only when no core port requests.
- R4: When the core level is below `dma_prio`, a new grant goes to DMA whenever `req_dma` is high. A core port is granted only when `req_dma` is low.
- R5: When the levels are equal, a new grant goes to the first requester found by scanning from a rotation pointer in the order program (0), X (1), Y (2), DMA (3), wrapping back to 0. Ports that are not requesting are skipped. After every new grant, whatever rule produced it, the pointer moves to one past the granted port.
- R6: When the core side wins a decision, the core ports are served in the fixed order program first, then X, then Y.
- R7: At most one of the grant bits `{gnt_dma, gnt_core[2:0]}` is high; bit i of `gnt_core` belongs to core port i (0 program, 1 X, 2 Y). `busy` is high exactly when a grant is high.
- R8: A granted port keeps its grant, unchanged by other requests or by any change of priority fields, for as long as its request stays high.
- R9: During and right after reset no grant is given, `busy` is low and the rotation pointer points at the program port.
- R10: Grants are registered: the grant seen after a clock edge is decided from the requests sampled at that edge. No port is granted unless it requested at that edge, and with no requests the bus goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_core | input | NCORE (3) | Core port requests: bit 0 program, bit 1 X, bit 2 Y |
| req_dma | input | 1 | DMA port request |
| mode_prio | input | 2 | Static core priority select; 00 means use the status field |
| stat_prio | input | 2 | Dynamic core priority level from the status word |
| dma_prio | input | 2 | Priority level of the active DMA channel |
| gnt_core | output | NCORE (3) | One-hot core port grants |
| gnt_dma | output | 1 | DMA port grant |
| busy | output | 1 | Bus owned by some requester this cycle |

## Verification
The bench sweeps every combination of mode field, status field, DMA level and request pattern. It then runs a long random request stream against an arithmetic model. The corner cases are ties between core and DMA levels, where a design with a wrong rotation would repeat a port or fail to skip idle ones, and the off-by-one mapping of static mode values, which would flip the winner at the boundaries. A holder whose request stays high while priorities change is also exercised, because a design that re-arbitrates every cycle would preempt it. Finally, a release cycle with no other requester must return the bus to idle rather than keep a stale grant.

// File: rtl/xba_pkg.sv
package xba_pkg;

  // width of every priority level field
  parameter int XBA_PW = 2;

  // outcome of the core-versus-DMA level comparison
  typedef enum logic [1:0] {
    CLS_CORE_HIGH = 2'd0,
    CLS_DMA_HIGH  = 2'd1,
    CLS_EQUAL     = 2'd2
  } cls_e;

  // effective core level: a zero mode field defers to the status field,
  // otherwise the static level is one below the mode field value
  function automatic logic [XBA_PW-1:0] eff_core_prio(
    input logic [XBA_PW-1:0] mode,
    input logic [XBA_PW-1:0] stat
  );
    if (mode == '0) return stat;
    return mode - XBA_PW'(1);
  endfunction

  // compare the two levels
  function automatic cls_e classify(
    input logic [XBA_PW-1:0] core_lvl,
    input logic [XBA_PW-1:0] dma_lvl
  );
    if (core_lvl > dma_lvl) return CLS_CORE_HIGH;
    if (core_lvl < dma_lvl) return CLS_DMA_HIGH;
    return CLS_EQUAL;
  endfunction

  // next rotation pointer: one past the granted port, wrapping at nreq
  function automatic int unsigned next_ptr(input int unsigned idx, input int unsigned nreq);
    return (idx + 1 >= nreq) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/xba_prio_resolve.sv
module xba_prio_resolve
  import xba_pkg::*;
(
  input  logic [XBA_PW-1:0] mode_prio,
  input  logic [XBA_PW-1:0] stat_prio,
  input  logic [XBA_PW-1:0] dma_prio,
  output logic [XBA_PW-1:0] core_lvl,
  output cls_e              cls
);

  always_comb begin
    core_lvl = eff_core_prio(mode_prio, stat_prio);
    cls      = classify(core_lvl, dma_prio);
  end

endmodule

// File: rtl/xba_pick.sv
module xba_pick
  import xba_pkg::*;
#(
  parameter int NCORE = 3,
  localparam int NREQ = NCORE + 1,
  localparam int IW   = $clog2(NREQ)
) (
  input  logic [NREQ-1:0] req,
  input  cls_e            cls,
  input  logic [IW-1:0]   ptr,
  output logic            win_valid,
  output logic [IW-1:0]   win_idx
);

  localparam logic [IW-1:0] DMA_IDX = IW'(NCORE);

  logic          core_any;
  logic [IW-1:0] core_idx;
  logic          rr_found;
  logic [IW-1:0] rr_idx;

  // fixed order inside the core group: lowest index first
  always_comb begin
    core_any = |req[NCORE-1:0];
    core_idx = '0;
    for (int i = NCORE - 1; i >= 0; i--) begin
      if (req[i]) core_idx = IW'(i);
    end
  end

  // rotation scan starting at the pointer
  always_comb begin
    rr_found = 1'b0;
    rr_idx   = '0;
    for (int k = 0; k < NREQ; k++) begin
      if (!rr_found && req[(int'(ptr) + k) % NREQ]) begin
        rr_found = 1'b1;
        rr_idx   = IW'((int'(ptr) + k) % NREQ);
      end
    end
  end

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    unique case (cls)
      CLS_CORE_HIGH: begin
        if (core_any) begin
          win_valid = 1'b1;
          win_idx   = core_idx;
        end else if (req[NCORE]) begin
          win_valid = 1'b1;
          win_idx   = DMA_IDX;
        end
      end
      CLS_DMA_HIGH: begin
        if (req[NCORE]) begin
          win_valid = 1'b1;
          win_idx   = DMA_IDX;
        end else if (core_any) begin
          win_valid = 1'b1;
          win_idx   = core_idx;
        end
      end
      default: begin
        win_valid = rr_found;
        win_idx   = rr_idx;
      end
    endcase
  end

endmodule

// File: rtl/xba_grant_reg.sv
module xba_grant_reg
  import xba_pkg::*;
#(
  parameter int NREQ = 4,
  localparam int IW  = $clog2(NREQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req,
  input  logic            win_valid,
  input  logic [IW-1:0]   win_idx,
  output logic [NREQ-1:0] gnt,
  output logic [IW-1:0]   ptr,
  output logic            hold,
  output logic            take
);

  logic [NREQ-1:0] gnt_new;

  always_comb begin
    hold    = |(gnt & req);
    take    = !hold && win_valid;
    gnt_new = '0;
    if (take) gnt_new[win_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt <= '0;
      ptr <= '0;
    end else if (!hold) begin
      gnt <= gnt_new;
      if (take) ptr <= IW'(next_ptr(int'(win_idx), NREQ));
    end
  end

endmodule

// File: rtl/xbus_arbiter.sv
module xbus_arbiter
  import xba_pkg::*;
#(
  parameter int NCORE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCORE-1:0]  req_core,
  input  logic              req_dma,
  input  logic [XBA_PW-1:0] mode_prio,
  input  logic [XBA_PW-1:0] stat_prio,
  input  logic [XBA_PW-1:0] dma_prio,
  output logic [NCORE-1:0]  gnt_core,
  output logic              gnt_dma,
  output logic              busy
);

  localparam int NREQ = NCORE + 1;
  localparam int IW   = $clog2(NREQ);

  // named internal events, visible to the bound checker
  logic [NREQ-1:0]   req_all;
  logic [NREQ-1:0]   gnt_all;
  logic [XBA_PW-1:0] core_lvl;
  cls_e              cls;
  logic              win_valid;
  logic [IW-1:0]     win_idx;
  logic [IW-1:0]     ptr;
  logic              hold;
  logic              take;

  assign req_all = {req_dma, req_core};

  xba_prio_resolve u_resolve (
    .mode_prio (mode_prio),
    .stat_prio (stat_prio),
    .dma_prio  (dma_prio),
    .core_lvl  (core_lvl),
    .cls       (cls)
  );

  xba_pick #(.NCORE(NCORE)) u_pick (
    .req       (req_all),
    .cls       (cls),
    .ptr       (ptr),
    .win_valid (win_valid),
    .win_idx   (win_idx)
  );

  xba_grant_reg #(.NREQ(NREQ)) u_grant (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req_all),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .gnt       (gnt_all),
    .ptr       (ptr),
    .hold      (hold),
    .take      (take)
  );

  assign gnt_core = gnt_all[NCORE-1:0];
  assign gnt_dma  = gnt_all[NCORE];
  assign busy     = |gnt_all;

endmodule

// File: rtl/xbus_arbiter_chk.sv
module xbus_arbiter_chk
  import xba_pkg::*;
#(
  parameter int NCORE = 3,
  localparam int NREQ = NCORE + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] req_all,
  input logic [NREQ-1:0] gnt_all,
  input cls_e            cls,
  input logic            hold
);

  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_all));

  p_grant_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && req_all == '0) |=> (gnt_all == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (gnt_all == $past(gnt_all)));

  p_dma_waits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && cls == CLS_CORE_HIGH && |req_all[NCORE-1:0]) |=> !gnt_all[NCORE]);

  p_core_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && cls == CLS_DMA_HIGH && req_all[NCORE]) |=> gnt_all[NCORE]);

  p_fixed_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && cls == CLS_CORE_HIGH && req_all[0]) |=> gnt_all[0]);

endmodule

bind xbus_arbiter xbus_arbiter_chk #(.NCORE(NCORE)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_all (req_all),
  .gnt_all (gnt_all),
  .cls     (cls),
  .hold    (hold)
);

// File: tb/test_xbus_arbiter.sv
module test_xbus_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] req_core = '0;
  logic       req_dma = 1'b0;
  logic [1:0] mode_prio = '0;
  logic [1:0] stat_prio = 2'd3;
  logic [1:0] dma_prio = '0;
  logic [2:0] gnt_core;
  logic       gnt_dma;
  logic       busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // model state: owner (-1 none) and rotation pointer
  int m_owner = -1;
  int m_ptr   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_arbiter i_xbus_arbiter (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_core  (req_core),
    .req_dma   (req_dma),
    .mode_prio (mode_prio),
    .stat_prio (stat_prio),
    .dma_prio  (dma_prio),
    .gnt_core  (gnt_core),
    .gnt_dma   (gnt_dma),
    .busy      (busy)
  );

  // core level per mode: 0 -> status, 1 -> 0, 2 -> 1, 3 -> 2
  function automatic int core_level(int m, int s);
    case (m)
      0: return s;
      1: return 0;
      2: return 1;
      default: return 2;
    endcase
  endfunction

  function automatic int first_core(logic [3:0] r);
    if (r[0]) return 0;
    if (r[1]) return 1;
    if (r[2]) return 2;
    return -1;
  endfunction

  function automatic int choose(logic [3:0] r, int m, int s, int d, int p);
    int c;
    c = core_level(m, s);
    if (c > d) return (first_core(r) >= 0) ? first_core(r) : (r[3] ? 3 : -1);
    if (c < d) return r[3] ? 3 : first_core(r);
    for (int k = 0; k < 4; k++) if (r[(p + k) & 3]) return (p + k) & 3;
    return -1;
  endfunction

  function automatic string tag_of(logic [3:0] r, int m, int s, int d);
    int c;
    c = core_level(m, s);
    if (m_owner >= 0 && r[m_owner]) return "R8";
    if (r == 4'b0) return "R10";
    if (c > d) return (r[2:0] != 0 && r[2:0] != 3'b001 && r[2:0] != 3'b010 && r[2:0] != 3'b100)
                      ? "R3 R6" : "R3";
    if (c < d) return "R4";
    return "R5";
  endfunction

  task automatic report(string tag, logic [3:0] got, logic [3:0] exp, logic got_b, logic exp_b);
    n_checks++;
    if (got !== exp || got_b !== exp_b) begin
      n_fail++;
      $display("FAIL %s: grants=%b busy=%b expected grants=%b busy=%b", tag, got, got_b, exp, exp_b);
    end
  endtask

  // apply one cycle of inputs, compute expected grant, sample after the edge
  task automatic cyc(logic [3:0] r, int m, int s, int d, string extra);
    string tag;
    int nxt;
    logic [3:0] expv;
    tag = {tag_of(r, m, s, d), extra};
    req_core  = r[2:0];
    req_dma   = r[3];
    mode_prio = 2'(m);
    stat_prio = 2'(s);
    dma_prio  = 2'(d);
    if (m_owner >= 0 && r[m_owner]) nxt = m_owner;
    else begin
      nxt = choose(r, m, s, d, m_ptr);
      if (nxt >= 0) m_ptr = (nxt + 1) % 4;
    end
    m_owner = nxt;
    expv = (nxt >= 0) ? 4'(1 << nxt) : 4'b0;
    @(posedge clk);
    #1;
    report({tag, " R7"}, {gnt_dma, gnt_core}, expv, busy, nxt >= 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got running expected done");
    finish_run();
  end

  initial begin
    // R9: reset state
    repeat (3) @(posedge clk);
    #1;
    report("R9 in reset", {gnt_dma, gnt_core}, 4'b0, busy, 1'b0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    report("R9 after reset", {gnt_dma, gnt_core}, 4'b0, busy, 1'b0);

    // R9/R5: pointer starts at program: equal levels, all request -> program
    cyc(4'b1111, 0, 0, 0, " R9");
    cyc(4'b0000, 0, 0, 0, "");

    // exhaustive sweep of mode, status, DMA level and request pattern
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 4; s++)
        for (int d = 0; d < 4; d++)
          for (int r = 1; r < 16; r++) begin
            cyc(4'(r), m, s, d, (m == 0) ? " R1" : " R2");
            cyc(4'b0000, m, s, d, "");
          end

    // R5: rotation with all requesting, each releasing after one cycle
    for (int i = 0; i < 8; i++) begin
      cyc(4'b1111, 0, 2, 2, " R5");
      cyc(4'b0000, 0, 2, 2, " R5");
    end

    // R8: DMA owns the bus, then core level rises above it while DMA holds
    cyc(4'b1000, 1, 0, 3, "");
    cyc(4'b1111, 0, 3, 0, " R8");
    cyc(4'b1111, 3, 1, 0, " R8");
    cyc(4'b0111, 3, 1, 0, " R3");
    cyc(4'b0110, 3, 1, 0, " R6");
    cyc(4'b0000, 3, 1, 0, "");

    // R2: status field changes under a static mode have no effect
    for (int s = 0; s < 4; s++) begin
      cyc(4'b1001, 2, s, 1, " R2");
      cyc(4'b0000, 2, s, 1, " R2");
    end

    // random stream with request holding
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] r;
      r = 4'($urandom_range(0, 15));
      if (m_owner >= 0 && ($urandom_range(0, 3) != 0)) r[m_owner] = 1'b1;
      cyc(r, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3), "");
    end

    finish_run();
  end

endmodule